// File: doc/BRIEF.md
# Sequential Modular Exponentiator with Selectable Scan Order

This block raises a 32-bit base to a 32-bit exponent modulo a 32-bit modulus. It accepts one job at a time, and only while it is idle. It then runs a loop of modular products on a single serial multiplier. The multiplier consumes one bit of its second operand per cycle, so its latency follows the data. When the job ends, the block raises a one-cycle completion pulse and keeps the answer on its result port until the next job is accepted.

A mode input picks one of two loop orderings:

- **Mode 0** walks the exponent from its least significant bit upward. It multiplies the accumulator by a running square only where the exponent bit is one.
- **Mode 1** walks from the highest one bit downward. After each squaring it always performs a multiply by the base, and it throws that product away when the bit is zero. This gives every exponent bit the same sequence of operations.

In both modes the loop ends once the highest one bit of the exponent has been consumed.

Top module: `sqmul_exp`

## Requirements
- R1: With modulus >= 2 and mode = 0, the result equals base^exponent mod modulus, for any base including base >= modulus.
- R2: With modulus >= 2 and mode = 1, the result equals base^exponent mod modulus.
- R3: If the modulus is 0 or 1 when a start is accepted, the result is 0 and `done` is high in the cycle right after the accepting clock edge.
- R4: If the exponent is 0 and the modulus is >= 2, the result is 1 and `done` is high in the cycle right after the accepting clock edge.
- R5: In mode 0, a zero exponent bit performs no multiply. With base 1, exponent 0xFFFFFFFF takes more cycles than exponent 0x80000000.
- R6: In mode 1, each exponent bit costs one square and one multiply whatever its value. With base 1, exponents 0xFFFFFFFF and 0x80000000 take the same number of cycles.
- R7: The loop stops after the highest one bit of the exponent. In both modes, exponent 1 finishes in fewer cycles than exponent 0x80000000.
- R8: `done` is a single-cycle pulse. `ready` is high whenever no job is running. `result` keeps its value from `done` until the next accepted start.
- R9: A `start` asserted while `ready` is low is ignored and does not change the running job's result.
- R10: After reset, `ready` is 1, `done` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept a job when `ready` is high |
| mode | input | 1 | 0: low-to-high scan, 1: high-to-low with multiply-always |
| base | input | 32 | Base operand |
| expo | input | 32 | Exponent (secret key) |
| modulus | input | 32 | Modulus |
| ready | output | 1 | Idle and able to accept a start |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Final value, held until the next accepted start |

## Verification
The in-line properties assume that a multiplier launch always has a first operand below the loaded modulus. This holds because every operand fed back into the multiplier is itself a reduced product, and the raw base only enters as the second operand of the initial reduction step, whose first operand is 1. The properties also assume that `start`, `mode` and the operands are stable when sampled. The stimulus respects this by changing them only on the falling clock edge and by holding the operands for the single accepting cycle. Bases at or above the modulus, a zero base, the all-ones modulus and the smallest legal modulus of 2 are all in the vector set, so the reduction path and the full 33-bit add-and-subtract range are exercised.

// File: rtl/sqmul_pkg.sv
// Shared types for the modular exponentiator.
// Assumes nothing beyond a single clock domain.
package sqmul_pkg;

    // Controller phases: idle, base reduction, squaring step, multiply step
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RED  = 2'd1,
        PH_SQR  = 2'd2,
        PH_MUL  = 2'd3
    } phase_t;

endpackage

// File: rtl/lead_one_find.sv
// Locates the index of the highest set bit of a word.
// Assumes the word is non-zero; a zero word returns index 0.
module lead_one_find #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  word,
    output logic [IW-1:0] top
);

    // Scan upward so the last set bit seen wins
    always_comb begin
        top = '0;
        for (int i = 0; i < W; i++) begin
            if (word[i]) top = IW'(i);
        end
    end

endmodule

// File: rtl/modmul_serial.sv
// Serial modular multiplier: prod = a * b mod n.
// Consumes one bit of b per cycle from the LSB, doubling a mod n each step,
// so latency is the bit length of b plus one cycle.
// Assumes a < n and n >= 2 at launch; b may take any value.
module modmul_serial #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] n,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] prod
);

    logic [W-1:0] r_q, aa_q, bb_q, nn_q;

    // Adds two residues below m and folds the sum back below m
    function automatic logic [W-1:0] add_mod(input logic [W-1:0] x,
                                             input logic [W-1:0] y,
                                             input logic [W-1:0] m);
        logic [W:0] s;
        s = {1'b0, x} + {1'b0, y};
        if (s >= {1'b0, m}) s = s - {1'b0, m};
        return s[W-1:0];
    endfunction

    // Launch, step through the multiplier bits, and flag completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            fin  <= 1'b0;
            r_q  <= '0;
            aa_q <= '0;
            bb_q <= '0;
            nn_q <= '0;
        end else begin
            fin <= 1'b0;
            if (go && !busy) begin
                busy <= 1'b1;
                r_q  <= '0;
                aa_q <= a;
                bb_q <= b;
                nn_q <= n;
            end else if (busy) begin
                if (bb_q == '0) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end else begin
                    if (bb_q[0]) r_q <= add_mod(r_q, aa_q, nn_q);
                    aa_q <= add_mod(aa_q, aa_q, nn_q);
                    bb_q <= bb_q >> 1;
                end
            end
        end
    end

    assign prod = r_q;

    // R1: every finished product is already reduced
    assert_prod_reduced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (prod < nn_q));

    // R1: a launch never arrives while a product is in flight
    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

    // R1: the first operand given at launch is below the modulus
    assert_operand_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (a < n));

endmodule

// File: rtl/sqmul_exp.sv
// Modular exponentiator: result = base^expo mod modulus.
// mode 0 scans the exponent upward and multiplies only on one bits;
// mode 1 scans downward from the top one bit and multiplies on every bit,
// discarding the product when the bit is zero.
// Assumes inputs are stable when start is sampled while ready is high.
module sqmul_exp #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         mode,
    input  logic [W-1:0] base,
    input  logic [W-1:0] expo,
    input  logic [W-1:0] modulus,
    output logic         ready,
    output logic         done,
    output logic [W-1:0] result
);
    import sqmul_pkg::*;

    localparam int IW = $clog2(W);

    phase_t       phase_q;
    logic         issued_q;
    logic         mode_q;
    logic [W-1:0] key_q, mod_q, base_q, acc_q, sq_q, result_q;
    logic [IW-1:0] idx_q, top_q, top_in;
    logic         done_q;

    logic         mul_go, mul_busy, mul_fin;
    logic [W-1:0] op_a, op_b, prod;

    lead_one_find #(.W(W), .IW(IW)) u_top (
        .word (expo),
        .top  (top_in)
    );

    // Select the multiplier operands for the current phase and mode
    always_comb begin
        op_a = '0;
        op_b = '0;
        case (phase_q)
            PH_RED: begin op_a = W'(1); op_b = base_q; end
            PH_SQR: begin
                op_a = mode_q ? acc_q : sq_q;
                op_b = mode_q ? acc_q : sq_q;
            end
            PH_MUL: begin
                op_a = acc_q;
                op_b = mode_q ? base_q : sq_q;
            end
            default: ;
        endcase
    end

    assign mul_go = (phase_q != PH_IDLE) && !issued_q;

    modmul_serial #(.W(W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (mul_go),
        .a     (op_a),
        .b     (op_b),
        .n     (mod_q),
        .busy  (mul_busy),
        .fin   (mul_fin),
        .prod  (prod)
    );

    // Sequence the job: accept, reduce the base, then walk the exponent bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            issued_q <= 1'b0;
            mode_q   <= 1'b0;
            key_q    <= '0;
            mod_q    <= '0;
            base_q   <= '0;
            acc_q    <= '0;
            sq_q     <= '0;
            idx_q    <= '0;
            top_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (mul_go) issued_q <= 1'b1;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        mode_q <= mode;
                        key_q  <= expo;
                        mod_q  <= modulus;
                        base_q <= base;
                        top_q  <= top_in;
                        acc_q  <= W'(1);
                        issued_q <= 1'b0;
                        if (modulus < W'(2)) begin
                            result_q <= '0;
                            done_q   <= 1'b1;
                        end else if (expo == '0) begin
                            result_q <= W'(1);
                            done_q   <= 1'b1;
                        end else begin
                            phase_q <= PH_RED;
                        end
                    end
                end
                PH_RED: begin
                    if (mul_fin) begin
                        issued_q <= 1'b0;
                        base_q   <= prod;
                        sq_q     <= prod;
                        if (mode_q) begin
                            idx_q   <= top_q;
                            phase_q <= PH_SQR;
                        end else begin
                            idx_q   <= '0;
                            phase_q <= key_q[0] ? PH_MUL : PH_SQR;
                        end
                    end
                end
                PH_SQR: begin
                    if (mul_fin) begin
                        issued_q <= 1'b0;
                        if (mode_q) begin
                            acc_q   <= prod;
                            phase_q <= PH_MUL;
                        end else begin
                            sq_q <= prod;
                            if (idx_q == top_q) begin
                                result_q <= acc_q;
                                done_q   <= 1'b1;
                                phase_q  <= PH_IDLE;
                            end else begin
                                idx_q   <= idx_q + 1'b1;
                                phase_q <= key_q[idx_q + 1'b1] ? PH_MUL : PH_SQR;
                            end
                        end
                    end
                end
                PH_MUL: begin
                    if (mul_fin) begin
                        issued_q <= 1'b0;
                        if (mode_q) begin
                            if (key_q[idx_q]) acc_q <= prod;
                            if (idx_q == '0) begin
                                result_q <= key_q[0] ? prod : acc_q;
                                done_q   <= 1'b1;
                                phase_q  <= PH_IDLE;
                            end else begin
                                idx_q   <= idx_q - 1'b1;
                                phase_q <= PH_SQR;
                            end
                        end else begin
                            acc_q   <= prod;
                            phase_q <= PH_SQR;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign ready  = (phase_q == PH_IDLE);
    assign done   = done_q;
    assign result = result_q;

    // R3: degenerate modulus gives zero on the next cycle
    assert_small_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && modulus < W'(2)) |=> (done && result == '0));

    // R4: zero exponent gives one on the next cycle
    assert_zero_expo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && modulus >= W'(2) && expo == '0) |=> (done && result == W'(1)));

    // R5: in mode 0 a multiply step only runs for a one bit
    assert_skip_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_MUL && !mode_q) |-> key_q[idx_q]);

    // R8: result does not move while idle unless a start was accepted
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ready) && !$past(start)) |-> $stable(result));

    // R8: completion is only flagged when idle
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    // R9: a start while busy leaves the loaded job untouched
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && start) |=> ($stable(mod_q) && $stable(key_q)));

    // R1: final result is reduced whenever the modulus allows it
    assert_result_reduced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result == '0 || result < mod_q));

endmodule

// File: tb/sim_sqmul_exp.sv
// Bench: vector table walked by one loop, then directed corner cases.
module sim_sqmul_exp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] base = '0, expo = '0, modulus = '0;
    logic        ready, done;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;   // 50 MHz

    sqmul_exp #(.W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .base(base), .expo(expo), .modulus(modulus),
        .ready(ready), .done(done), .result(result)
    );

    // {mode, base, expo, modulus}
    localparam logic [96:0] VECS [0:9] = '{
        {1'b0, 32'd5,          32'd3,          32'd13},
        {1'b1, 32'd5,          32'd3,          32'd13},
        {1'b0, 32'h12345678,   32'h00010001,   32'hFFFFFFFB},
        {1'b1, 32'h12345678,   32'h00010001,   32'hFFFFFFFB},
        {1'b0, 32'd100,        32'd7,          32'd17},
        {1'b1, 32'd2,          32'hFFFFFFFF,   32'd1000003},
        {1'b0, 32'd0,          32'd5,          32'd7},
        {1'b1, 32'hFFFFFFFF,   32'h80000000,   32'hFFFFFFFF},
        {1'b0, 32'd3,          32'd1,          32'd2},
        {1'b1, 32'd7,          32'd2,          32'h80000000}
    };

    function automatic logic [31:0] ref_pow(input logic [31:0] c,
                                            input logic [31:0] d,
                                            input logic [31:0] n);
        logic [63:0] r, b;
        if (n < 2) return 32'd0;
        r = 64'd1;
        b = {32'd0, c} % {32'd0, n};
        for (int i = 0; i < 32; i++) begin
            if (d[i]) r = (r * b) % {32'd0, n};
            b = (b * b) % {32'd0, n};
        end
        return r[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic m, input logic [31:0] c, input logic [31:0] d,
                       input logic [31:0] n, output logic [31:0] res, output int lat);
        while (!ready) @(negedge clk);
        mode = m; base = c; expo = d; modulus = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done) begin
            @(negedge clk);
            lat++;
        end
        res = result;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] res, res2;
        int lat, lat_a, lat_b;

        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 ready", {31'd0, ready}, 32'd1);
        check("R10 done", {31'd0, done}, 32'd0);
        check("R10 result", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 (mode 0) and R2 (mode 1): table of vectors
        for (int v = 0; v < 10; v++) begin
            run(VECS[v][96], VECS[v][95:64], VECS[v][63:32], VECS[v][31:0], res, lat);
            check(VECS[v][96] ? "R2 vector" : "R1 vector", res,
                  ref_pow(VECS[v][95:64], VECS[v][63:32], VECS[v][31:0]));
        end

        // R3: modulus 0 and 1
        run(1'b0, 32'd9, 32'd5, 32'd0, res, lat);
        check("R3 mod0 result", res, 32'd0);
        check("R3 mod0 latency", lat, 32'd1);
        run(1'b1, 32'd9, 32'd5, 32'd1, res, lat);
        check("R3 mod1 result", res, 32'd0);
        check("R3 mod1 latency", lat, 32'd1);

        // R4: zero exponent
        run(1'b0, 32'd9, 32'd0, 32'd11, res, lat);
        check("R4 result", res, 32'd1);
        check("R4 latency", lat, 32'd1);

        // R5: mode 0 skips multiplies on zero bits
        run(1'b0, 32'd1, 32'hFFFFFFFF, 32'd1000003, res, lat_a);
        run(1'b0, 32'd1, 32'h80000000, 32'd1000003, res, lat_b);
        check("R5 all-ones slower", {31'd0, lat_a > lat_b}, 32'd1);

        // R6: mode 1 equal work per bit
        run(1'b1, 32'd1, 32'hFFFFFFFF, 32'd1000003, res, lat_a);
        run(1'b1, 32'd1, 32'h80000000, 32'd1000003, res, lat_b);
        check("R6 equal latency", lat_a, lat_b);

        // R7: runtime follows the top one bit
        run(1'b0, 32'd1, 32'd1, 32'd1000003, res, lat_a);
        run(1'b0, 32'd1, 32'h80000000, 32'd1000003, res, lat_b);
        check("R7 mode0 shorter", {31'd0, lat_a < lat_b}, 32'd1);
        run(1'b1, 32'd1, 32'd1, 32'd1000003, res, lat_a);
        run(1'b1, 32'd1, 32'h80000000, 32'd1000003, res, lat_b);
        check("R7 mode1 shorter", {31'd0, lat_a < lat_b}, 32'd1);

        // R8: single-cycle done, ready while idle, result held
        run(1'b0, 32'd5, 32'd3, 32'd13, res, lat);
        check("R8 ready at done", {31'd0, ready}, 32'd1);
        @(negedge clk);
        check("R8 done pulse", {31'd0, done}, 32'd0);
        repeat (5) @(negedge clk);
        check("R8 result hold", result, 32'd8);

        // R9: start while busy is ignored
        mode = 1'b0; base = 32'd5; expo = 32'd3; modulus = 32'd13; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 busy after start", {31'd0, ready}, 32'd0);
        @(negedge clk);
        base = 32'd2; expo = 32'd10; modulus = 32'd1000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        res2 = result;
        check("R9 ignored start", res2, 32'd8);
        repeat (3) @(negedge clk);
        check("R9 no second job", {31'd0, ready}, 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule